// File: doc/BRIEF.md
# Four-Layer Two-Pipe Compositor

This block merges up to four rectangular layers into a single RGB stream, one pixel per clock. A raster position enters with its x and y counters and one ARGB pixel per layer. The block works in two steps. First, every enabled layer is steered to one of two pipes, and inside each pipe the layer with the highest priority that covers the position supplies the pixel. Second, the pipe 1 pixel is alpha-blended over the pipe 0 pixel. Pipe 0 itself is opaque and sits on a fixed background colour.

Each layer has an enable, an origin, a size, a pipe select, a priority and an 8-bit global alpha with its own enable. A display-size pair bounds the active area. An interlace switch turns the line counter into a field line, so layers are placed in frame coordinates. A build parameter can reproduce a known defect: on such parts, a pipe 0 layer of priority 0 that carries any transparency is shown as background. Fetching pixels from memory and scaling them happen upstream of this block.

Top module: `dual_pipe_compositor`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid_o` is 0 and `out_rgb_o` is 0.
- R2: `out_valid_o` repeats `pix_valid_i` exactly two clock cycles later. Whenever `out_valid_o` is 0, `out_rgb_o` is 0.
- R3: Layer i covers a position when its enable bit is 1, `x_i <= x < x_i + w_i` and `y_i <= y < y_i + h_i`. Coordinates are unsigned and the sums do not wrap. A disabled layer never affects the output.
- R4: Within a pipe (`layer_pipe_i` bit i: 0 or 1), the covering layer with the largest priority field supplies the pixel. When priorities are equal, the lower layer index wins.
- R5: Pixel buses are laid out as {A[31:24], R[23:16], G[15:8], B[7:0]}. When pipe 1 has a winner with alpha A, each output channel is (A*top + (255-A)*bottom + 127)/255, using integer division. The bottom is the pipe 0 result.
- R6: When a layer's global-alpha enable is 1, its effective alpha is (A_pixel*G + 127)/255. When the enable is 0, its effective alpha is A_pixel. The alpha of the pipe 0 winner never affects its colour.
- R7: If no layer covers the position in pipe 0, the bottom is the background colour (parameter, black by default). If no layer covers it in pipe 1, the bottom is output unchanged.
- R8: A position with x >= display width, or with effective line >= display height, outputs the background colour.
- R9: With interlace enabled, the effective line is 2*y + field bit. Otherwise the effective line is y.
- R10: With the defect parameter set to 1, a pipe 0 winner whose priority is 0 and whose effective alpha is below 255 shows the background colour. With the parameter at 0 it shows its own colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid_i | input | 1 | Raster position and pixel buses are valid |
| ras_x_i | input | COORD_W | Raster column |
| ras_y_i | input | COORD_W | Raster line (a field line when interlaced) |
| field_odd_i | input | 1 | Field parity used in interlace mode |
| interlace_en_i | input | 1 | Interlace mode enable |
| disp_w_i | input | COORD_W | Active display width |
| disp_h_i | input | COORD_W | Active display height in frame lines |
| layer_en_i | input | NUM_LAYERS | Per-layer enable |
| layer_pipe_i | input | NUM_LAYERS | Per-layer pipe select |
| layer_prio_i | input | NUM_LAYERS*PRIO_W | Per-layer priority |
| layer_x_i | input | NUM_LAYERS*COORD_W | Per-layer left edge |
| layer_y_i | input | NUM_LAYERS*COORD_W | Per-layer top edge (frame lines) |
| layer_w_i | input | NUM_LAYERS*COORD_W | Per-layer width |
| layer_h_i | input | NUM_LAYERS*COORD_W | Per-layer height |
| glb_alpha_i | input | NUM_LAYERS*8 | Per-layer global alpha |
| glb_alpha_en_i | input | NUM_LAYERS | Per-layer global alpha enable |
| layer_argb_i | input | NUM_LAYERS*32 | Per-layer ARGB pixel at the current position |
| out_valid_o | output | 1 | Output pixel valid |
| out_rgb_o | output | 24 | Composited RGB pixel |

## Verification
The bench sweeps every position of a small raster under several layer setups and runs two copies of the block, one with the defect parameter and one without.

It targets these corner cases:
- Two equal-priority layers that overlap. A design with the tie broken the wrong way shows the higher-indexed layer's colour in the overlap.
- An x-dependent alpha on pipe 1, which spans the blend rounding. A wrong rounding or channel ordering gives values off by one or swapped.
- A global alpha of 255 on an opaque layer. This must not trip the defect path.
- An interlaced setup whose display size cuts off layers partway. A wrong line mapping or blanking shows layer colour where background is due.
- Disabled layers placed over the whole sweep, and idle gaps in the input stream. These catch a leaking enable and a stale or misaligned valid.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int CH_W   = 8;
    localparam int RGB_W  = 3 * CH_W;
    localparam int ARGB_W = 4 * CH_W;
    localparam logic [CH_W-1:0] ALPHA_FULL = 8'hFF;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } argb_t;

    // Winner of one pipe: coverage flag, effective alpha, colour.
    typedef struct packed {
        logic             hit;
        logic [CH_W-1:0]  alpha;
        logic [RGB_W-1:0] rgb;
    } pipe_px_t;

    // (p*q + 127) / 255, rounded product of two unit fractions.
    function automatic logic [CH_W-1:0] mul_norm(input logic [CH_W-1:0] p,
                                                 input logic [CH_W-1:0] q);
        logic [15:0] t;
        t = 16'(p) * 16'(q) + 16'd127;
        return CH_W'(t / 16'd255);
    endfunction

    function automatic logic [CH_W-1:0] blend_ch(input logic [CH_W-1:0] a,
                                                 input logic [CH_W-1:0] top,
                                                 input logic [CH_W-1:0] bot);
        logic [15:0] s;
        s = 16'(a) * 16'(top) + 16'(ALPHA_FULL - a) * 16'(bot) + 16'd127;
        return CH_W'(s / 16'd255);
    endfunction

    function automatic logic [RGB_W-1:0] blend_rgb(input logic [CH_W-1:0] a,
                                                   input logic [RGB_W-1:0] top,
                                                   input logic [RGB_W-1:0] bot);
        logic [RGB_W-1:0] res;
        for (int c = 0; c < 3; c++) begin
            res[c*CH_W +: CH_W] = blend_ch(a, top[c*CH_W +: CH_W], bot[c*CH_W +: CH_W]);
        end
        return res;
    endfunction

endpackage

// File: rtl/cmp_layer_hit.sv
module cmp_layer_hit #(
    parameter int COORD_W = 12
) (
    input  logic               en_i,
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W:0]   line_i,
    input  logic [COORD_W-1:0] org_x_i,
    input  logic [COORD_W-1:0] org_y_i,
    input  logic [COORD_W-1:0] size_w_i,
    input  logic [COORD_W-1:0] size_h_i,
    output logic               hit_o
);
    // One extra bit keeps the far edge from wrapping.
    logic [COORD_W:0] x_wide, x_lo, x_hi, y_lo, y_hi;

    always_comb begin
        x_wide = {1'b0, x_i};
        x_lo   = {1'b0, org_x_i};
        y_lo   = {1'b0, org_y_i};
        x_hi   = x_lo + {1'b0, size_w_i};
        y_hi   = y_lo + {1'b0, size_h_i};
        hit_o  = en_i && (x_wide >= x_lo) && (x_wide < x_hi)
                      && (line_i >= y_lo) && (line_i < y_hi);
    end
endmodule

// File: rtl/cmp_pipe_arbiter.sv
module cmp_pipe_arbiter
    import cmp_pkg::*;
#(
    parameter int               NUM_LAYERS    = 4,
    parameter int               PRIO_W        = 2,
    parameter logic             PIPE_ID       = 1'b0,
    parameter logic             LOW_ALPHA_BUG = 1'b0,
    parameter logic [RGB_W-1:0] BG_RGB        = '0
) (
    input  logic [NUM_LAYERS-1:0]        hit_i,
    input  logic [NUM_LAYERS-1:0]        pipe_sel_i,
    input  logic [NUM_LAYERS*PRIO_W-1:0] prio_i,
    input  logic [NUM_LAYERS*ARGB_W-1:0] argb_i,
    input  logic [NUM_LAYERS*CH_W-1:0]   galpha_i,
    input  logic [NUM_LAYERS-1:0]        galpha_en_i,
    output pipe_px_t                     px_o,
    output logic [NUM_LAYERS-1:0]        grant_o
);
    localparam int IDX_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1;

    logic              found;
    logic [IDX_W-1:0]  best_idx;
    logic [PRIO_W-1:0] best_prio;
    argb_t             win_px;
    logic [CH_W-1:0]   eff_alpha;
    logic              hide;

    // Strictly-greater compare in ascending index order: ties keep the lower index.
    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_LAYERS; i++) begin
            if (hit_i[i] && (pipe_sel_i[i] == PIPE_ID) &&
                (!found || (prio_i[i*PRIO_W +: PRIO_W] > best_prio))) begin
                found     = 1'b1;
                best_idx  = IDX_W'(i);
                best_prio = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    always_comb begin
        win_px    = argb_t'(argb_i[int'(best_idx)*ARGB_W +: ARGB_W]);
        eff_alpha = galpha_en_i[best_idx]
                  ? mul_norm(win_px.a, galpha_i[int'(best_idx)*CH_W +: CH_W])
                  : win_px.a;
        hide      = LOW_ALPHA_BUG && found && (best_prio == '0) && (eff_alpha != ALPHA_FULL);
        grant_o   = found ? (NUM_LAYERS'(1) << best_idx) : '0;
        px_o.hit  = found;
        px_o.alpha = found ? eff_alpha : '0;
        px_o.rgb   = (!found || hide) ? BG_RGB : {win_px.r, win_px.g, win_px.b};
    end
endmodule

// File: rtl/cmp_pipe_blend.sv
module cmp_pipe_blend
    import cmp_pkg::*;
(
    input  pipe_px_t          top_i,
    input  logic [RGB_W-1:0]  bot_i,
    output logic [RGB_W-1:0]  rgb_o
);
    always_comb begin
        rgb_o = top_i.hit ? blend_rgb(top_i.alpha, top_i.rgb, bot_i) : bot_i;
    end
endmodule

// File: rtl/dual_pipe_compositor.sv
module dual_pipe_compositor
    import cmp_pkg::*;
#(
    parameter int               NUM_LAYERS          = 4,
    parameter int               COORD_W             = 12,
    parameter int               PRIO_W              = 2,
    parameter logic [RGB_W-1:0] BG_RGB              = 24'h000000,
    parameter logic             LOW_PLANE_ALPHA_BUG = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          pix_valid_i,
    input  logic [COORD_W-1:0]            ras_x_i,
    input  logic [COORD_W-1:0]            ras_y_i,
    input  logic                          field_odd_i,
    input  logic                          interlace_en_i,
    input  logic [COORD_W-1:0]            disp_w_i,
    input  logic [COORD_W-1:0]            disp_h_i,
    input  logic [NUM_LAYERS-1:0]         layer_en_i,
    input  logic [NUM_LAYERS-1:0]         layer_pipe_i,
    input  logic [NUM_LAYERS*PRIO_W-1:0]  layer_prio_i,
    input  logic [NUM_LAYERS*COORD_W-1:0] layer_x_i,
    input  logic [NUM_LAYERS*COORD_W-1:0] layer_y_i,
    input  logic [NUM_LAYERS*COORD_W-1:0] layer_w_i,
    input  logic [NUM_LAYERS*COORD_W-1:0] layer_h_i,
    input  logic [NUM_LAYERS*CH_W-1:0]    glb_alpha_i,
    input  logic [NUM_LAYERS-1:0]         glb_alpha_en_i,
    input  logic [NUM_LAYERS*ARGB_W-1:0]  layer_argb_i,
    output logic                          out_valid_o,
    output logic [RGB_W-1:0]              out_rgb_o
);
    localparam int NUM_PIPES = 2;

    // ---------------- stage 0: coverage and per-pipe selection
    logic [COORD_W:0]      frame_line;
    logic                  in_area;
    logic [NUM_LAYERS-1:0] layer_hit;
    pipe_px_t              pipe_px [NUM_PIPES];
    logic [NUM_LAYERS-1:0] pipe_grant [NUM_PIPES];
    logic [NUM_LAYERS-1:0] grant_p0, grant_p1;

    always_comb begin
        frame_line = interlace_en_i ? {ras_y_i, field_odd_i} : {1'b0, ras_y_i};
        in_area    = ({1'b0, ras_x_i} < {1'b0, disp_w_i}) && (frame_line < {1'b0, disp_h_i});
    end

    for (genvar li = 0; li < NUM_LAYERS; li++) begin : g_layer
        cmp_layer_hit #(.COORD_W(COORD_W)) u_hit (
            .en_i     (layer_en_i[li]),
            .x_i      (ras_x_i),
            .line_i   (frame_line),
            .org_x_i  (layer_x_i[li*COORD_W +: COORD_W]),
            .org_y_i  (layer_y_i[li*COORD_W +: COORD_W]),
            .size_w_i (layer_w_i[li*COORD_W +: COORD_W]),
            .size_h_i (layer_h_i[li*COORD_W +: COORD_W]),
            .hit_o    (layer_hit[li])
        );
    end

    for (genvar pi = 0; pi < NUM_PIPES; pi++) begin : g_pipe
        cmp_pipe_arbiter #(
            .NUM_LAYERS    (NUM_LAYERS),
            .PRIO_W        (PRIO_W),
            .PIPE_ID       (pi[0]),
            .LOW_ALPHA_BUG ((pi == 0) ? LOW_PLANE_ALPHA_BUG : 1'b0),
            .BG_RGB        (BG_RGB)
        ) u_arb (
            .hit_i       (layer_hit),
            .pipe_sel_i  (layer_pipe_i),
            .prio_i      (layer_prio_i),
            .argb_i      (layer_argb_i),
            .galpha_i    (glb_alpha_i),
            .galpha_en_i (glb_alpha_en_i),
            .px_o        (pipe_px[pi]),
            .grant_o     (pipe_grant[pi])
        );
    end

    assign grant_p0 = pipe_grant[0];
    assign grant_p1 = pipe_grant[1];

    // Pipe 0 is opaque over the background; its alpha has no use here.
    logic unused_p0_alpha;
    assign unused_p0_alpha = &{1'b0, pipe_px[0].alpha, pipe_px[0].hit};

    // ---------------- stage 1 registers
    logic             s1_valid;
    logic             s1_active;
    pipe_px_t         s1_top;
    logic [RGB_W-1:0] s1_bot;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1_active <= 1'b0;
            s1_top    <= '0;
            s1_bot    <= '0;
        end else begin
            s1_valid  <= pix_valid_i;
            s1_active <= in_area;
            s1_top    <= pipe_px[1];
            s1_bot    <= pipe_px[0].rgb;
        end
    end

    // ---------------- stage 2: blend pipe 1 over pipe 0
    logic [RGB_W-1:0] mix_rgb;

    cmp_pipe_blend u_blend (
        .top_i (s1_top),
        .bot_i (s1_bot),
        .rgb_o (mix_rgb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            out_rgb_o   <= '0;
        end else begin
            out_valid_o <= s1_valid;
            if (!s1_valid)       out_rgb_o <= '0;
            else if (!s1_active) out_rgb_o <= BG_RGB;
            else                 out_rgb_o <= mix_rgb;
        end
    end
endmodule

// File: rtl/cmp_checker.sv
module cmp_checker
    import cmp_pkg::*;
#(
    parameter int               NUM_LAYERS = 4,
    parameter logic [RGB_W-1:0] BG_RGB     = '0
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  pix_valid_i,
    input logic                  out_valid_o,
    input logic [RGB_W-1:0]      out_rgb_o,
    input logic                  s1_valid,
    input logic                  s1_active,
    input pipe_px_t              s1_top,
    input logic [RGB_W-1:0]      s1_bot,
    input logic [NUM_LAYERS-1:0] grant_p0,
    input logic [NUM_LAYERS-1:0] grant_p1
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!out_valid_o && out_rgb_o == '0)); // R1

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid_o == $past(pix_valid_i, 2))); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_valid_o |-> (out_rgb_o == '0)); // R2

    AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_p0) && $onehot0(grant_p1) && ((grant_p0 & grant_p1) == '0)); // R4

    AST_OPAQUE_TOP: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_active && s1_top.hit && s1_top.alpha == ALPHA_FULL)
        |=> (out_rgb_o == $past(s1_top.rgb))); // R5

    AST_EMPTY_TOP: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_active && !s1_top.hit) |=> (out_rgb_o == $past(s1_bot))); // R7

    AST_BLANK_AREA: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_active) |=> (out_rgb_o == BG_RGB)); // R8
endmodule

bind dual_pipe_compositor cmp_checker #(
    .NUM_LAYERS (NUM_LAYERS),
    .BG_RGB     (BG_RGB)
) u_cmp_checker (
    .clk         (clk),
    .rst         (rst),
    .pix_valid_i (pix_valid_i),
    .out_valid_o (out_valid_o),
    .out_rgb_o   (out_rgb_o),
    .s1_valid    (s1_valid),
    .s1_active   (s1_active),
    .s1_top      (s1_top),
    .s1_bot      (s1_bot),
    .grant_p0    (grant_p0),
    .grant_p1    (grant_p1)
);

// File: tb/dual_pipe_compositor_bench.sv
module dual_pipe_compositor_bench;

    localparam int NL = 4;
    localparam int CW = 12;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             pix_valid = 1'b0;
    logic [CW-1:0]    ras_x = '0, ras_y = '0;
    logic             field_odd = 1'b0, ilace_en = 1'b0;
    logic [CW-1:0]    disp_w = '0, disp_h = '0;
    logic [NL-1:0]    l_en = '0, l_pipe = '0, l_gae = '0;
    logic [NL*PW-1:0] l_prio = '0;
    logic [NL*CW-1:0] l_x = '0, l_y = '0, l_w = '0, l_h = '0;
    logic [NL*8-1:0]  l_ga = '0;
    logic [NL*32-1:0] l_argb = '0;
    logic             ov [2];
    logic [23:0]      orgb [2];

    dual_pipe_compositor #(.LOW_PLANE_ALPHA_BUG(1'b0)) u_dual_pipe_compositor (
        .clk(clk), .rst(rst), .pix_valid_i(pix_valid), .ras_x_i(ras_x), .ras_y_i(ras_y),
        .field_odd_i(field_odd), .interlace_en_i(ilace_en), .disp_w_i(disp_w), .disp_h_i(disp_h),
        .layer_en_i(l_en), .layer_pipe_i(l_pipe), .layer_prio_i(l_prio), .layer_x_i(l_x),
        .layer_y_i(l_y), .layer_w_i(l_w), .layer_h_i(l_h), .glb_alpha_i(l_ga),
        .glb_alpha_en_i(l_gae), .layer_argb_i(l_argb), .out_valid_o(ov[0]), .out_rgb_o(orgb[0])
    );

    dual_pipe_compositor #(.LOW_PLANE_ALPHA_BUG(1'b1)) u_dual_pipe_compositor_quirk (
        .clk(clk), .rst(rst), .pix_valid_i(pix_valid), .ras_x_i(ras_x), .ras_y_i(ras_y),
        .field_odd_i(field_odd), .interlace_en_i(ilace_en), .disp_w_i(disp_w), .disp_h_i(disp_h),
        .layer_en_i(l_en), .layer_pipe_i(l_pipe), .layer_prio_i(l_prio), .layer_x_i(l_x),
        .layer_y_i(l_y), .layer_w_i(l_w), .layer_h_i(l_h), .glb_alpha_i(l_ga),
        .glb_alpha_en_i(l_gae), .layer_argb_i(l_argb), .out_valid_o(ov[1]), .out_rgb_o(orgb[1])
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench-side configuration
    int cx[NL], cy[NL], cw[NL], ch[NL], cprio[NL], ca[NL], cadx[NL], cga[NL];
    bit cen[NL], cpipe[NL], cgae[NL];
    int dw, dh;
    bit cil;
    string cfg_tag;

    // expected pipeline: slot 0 newest, slot 1 due now; index [inst]
    bit          ev [2];
    logic [23:0] erg [2][2];
    string       etg [2][2];

    function automatic logic [31:0] pix(input int i, input int x, input int y);
        int a, r, g, b;
        a = (ca[i] + x * cadx[i]) % 256;
        r = (x * 16 + i * 40) % 256;
        g = (y * 20 + i * 7) % 256;
        b = ((x ^ y) * 9 + i * 50) % 256;
        return {8'(a), 8'(r), 8'(g), 8'(b)};
    endfunction

    function automatic int eff_a(input int i, input int x, input int y);
        int a;
        a = int'(pix(i, x, y) >> 24);
        return cgae[i] ? (a * cga[i] + 127) / 255 : a;
    endfunction

    function automatic void model(input int x, input int y, input int f, input bit q,
                                  output logic [23:0] rgb, output string tag);
        int ey, best [2];
        logic [23:0] bot, top;
        int av;
        ey = cil ? 2 * y + f : y;
        if (x >= dw || ey >= dh) begin
            rgb = 24'h0; tag = {cfg_tag, "/R8"}; return;
        end
        for (int p = 0; p < 2; p++) begin
            best[p] = -1;
            for (int i = 0; i < NL; i++) begin
                if (cen[i] && int'(cpipe[i]) == p && x >= cx[i] && x < cx[i] + cw[i] &&
                    ey >= cy[i] && ey < cy[i] + ch[i] &&
                    (best[p] < 0 || cprio[i] > cprio[best[p]]))
                    best[p] = i;
            end
        end
        if (best[0] < 0) begin
            bot = 24'h0; tag = {cfg_tag, "/R7"};
        end else if (q && cprio[best[0]] == 0 && eff_a(best[0], x, y) < 255) begin
            bot = 24'h0; tag = {cfg_tag, "/R10"};
        end else begin
            bot = pix(best[0], x, y) & 24'hFFFFFF; tag = {cfg_tag, "/R4"};
        end
        if (best[1] < 0) begin
            rgb = bot;
        end else begin
            av  = eff_a(best[1], x, y);
            top = pix(best[1], x, y) & 24'hFFFFFF;
            for (int c = 0; c < 3; c++)
                rgb[c*8 +: 8] = 8'((av * int'(top[c*8 +: 8]) + (255 - av) * int'(bot[c*8 +: 8]) + 127) / 255);
            tag = {tag, cgae[best[1]] ? "+R6" : "+R5"};
        end
    endfunction

    task automatic check_slot();
        for (int k = 0; k < 2; k++) begin
            checks++;
            if (ov[k] !== ev[1] || orgb[k] !== (ev[1] ? erg[1][k] : 24'h0)) begin
                errors++;
                $display("FAIL %s inst%0d valid %0b rgb %06h expected valid %0b rgb %06h",
                         ev[1] ? etg[1][k] : "R2", k, ov[k], orgb[k], ev[1],
                         ev[1] ? erg[1][k] : 24'h0);
            end
        end
    endtask

    task automatic step(input bit v, input int x, input int y, input int f);
        @(negedge clk);
        check_slot();
        ev[1] = ev[0];
        for (int k = 0; k < 2; k++) begin erg[1][k] = erg[0][k]; etg[1][k] = etg[0][k]; end
        pix_valid = v; ras_x = CW'(x); ras_y = CW'(y); field_odd = f[0];
        ilace_en = cil; disp_w = CW'(dw); disp_h = CW'(dh);
        for (int i = 0; i < NL; i++) begin
            l_en[i] = cen[i]; l_pipe[i] = cpipe[i]; l_gae[i] = cgae[i];
            l_prio[i*PW +: PW] = PW'(cprio[i]);
            l_x[i*CW +: CW] = CW'(cx[i]); l_y[i*CW +: CW] = CW'(cy[i]);
            l_w[i*CW +: CW] = CW'(cw[i]); l_h[i*CW +: CW] = CW'(ch[i]);
            l_ga[i*8 +: 8] = 8'(cga[i]);
            l_argb[i*32 +: 32] = pix(i, x, y);
        end
        ev[0] = v;
        for (int k = 0; k < 2; k++) model(x, y, f, k[0], erg[0][k], etg[0][k]);
    endtask

    task automatic sweep(input int nf);
        int n = 0;
        for (int y = 0; y < 12; y++)
            for (int f = 0; f < nf; f++)
                for (int x = 0; x < 24; x++) begin
                    if (n % 7 == 3) step(1'b0, x, y, f); // R2: idle gap
                    step(1'b1, x, y, f);
                    n++;
                end
    endtask

    task automatic clear_cfg(input string tag);
        for (int i = 0; i < NL; i++) begin
            cen[i] = 0; cpipe[i] = 0; cgae[i] = 0; cprio[i] = 0;
            cx[i] = 0; cy[i] = 0; cw[i] = 0; ch[i] = 0;
            ca[i] = 255; cadx[i] = 0; cga[i] = 255;
        end
        dw = 4095; dh = 4095; cil = 0; cfg_tag = tag;
    endtask

    task automatic set_layer(input int i, input bit en, input bit p, input int pr,
                             input int x, input int y, input int w, input int h,
                             input int a, input int adx, input bit gae, input int ga);
        cen[i] = en; cpipe[i] = p; cprio[i] = pr; cx[i] = x; cy[i] = y; cw[i] = w; ch[i] = h;
        ca[i] = a; cadx[i] = adx; cgae[i] = gae; cga[i] = ga;
    endtask

    initial begin
        ev[0] = 0; ev[1] = 0;
        for (int k = 0; k < 2; k++) begin erg[0][k] = 0; erg[1][k] = 0; etg[0][k] = "R2"; etg[1][k] = "R2"; end
        clear_cfg("R1");
        // R1: outputs stay idle through reset
        repeat (4) begin
            @(negedge clk);
            for (int k = 0; k < 2; k++) begin
                checks++;
                if (ov[k] !== 1'b0 || orgb[k] !== 24'h0) begin
                    errors++;
                    $display("FAIL R1 inst%0d valid %0b rgb %06h expected 0 000000", k, ov[k], orgb[k]);
                end
            end
        end
        rst = 1'b0;
        // R1: first cycle after reset release is still idle
        step(1'b0, 0, 0, 0);

        // R3: disabled layers over the whole sweep leave only background
        clear_cfg("R3");
        for (int i = 0; i < NL; i++) set_layer(i, 0, i[0], i % 4, 0, 0, 30, 30, 200, 0, 0, 255);
        sweep(1);

        // R4 ties and priorities, R5 x-dependent alpha on pipe 1
        clear_cfg("C1");
        set_layer(0, 1, 0, 0, 0, 0, 24, 12, 255, 0, 0, 255);
        set_layer(1, 1, 0, 2, 3, 2, 8, 5, 255, 0, 0, 255);
        set_layer(2, 1, 0, 2, 6, 4, 8, 6, 255, 0, 0, 255);
        set_layer(3, 1, 1, 1, 10, 1, 10, 8, 0, 11, 0, 255);
        sweep(1);

        // R6 global alpha, R10 translucent lowest plane
        clear_cfg("C2");
        set_layer(0, 1, 0, 0, 0, 0, 20, 10, 100, 0, 0, 255);
        set_layer(1, 1, 0, 1, 2, 2, 5, 4, 255, 0, 1, 255);
        set_layer(2, 1, 1, 3, 12, 3, 8, 6, 255, 0, 1, 200);
        set_layer(3, 1, 1, 1, 8, 0, 8, 12, 60, 7, 1, 128);
        sweep(1);

        // R9 interlace with R8 display cut-off
        clear_cfg("R9");
        dw = 20; dh = 18; cil = 1;
        set_layer(0, 1, 0, 3, 0, 0, 24, 6, 255, 0, 0, 255);
        set_layer(1, 1, 0, 1, 4, 5, 10, 10, 255, 0, 0, 255);
        set_layer(3, 1, 1, 0, 2, 15, 20, 20, 180, 0, 1, 77);
        sweep(2);

        // R10 not tripped by opaque global 255; R7 transparent pipe 1; R3 disabled overlap
        clear_cfg("C4");
        set_layer(0, 1, 0, 0, 0, 0, 24, 12, 255, 0, 1, 255);
        set_layer(1, 1, 1, 0, 5, 2, 6, 4, 0, 0, 0, 255);
        set_layer(2, 0, 1, 3, 0, 0, 24, 12, 255, 0, 0, 255);
        set_layer(3, 1, 1, 2, 20, 9, 4095, 4095, 255, 0, 0, 255);
        sweep(1);

        step(1'b0, 0, 0, 0);
        step(1'b0, 0, 0, 0);
        step(1'b0, 0, 0, 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule